// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is the digital core of an I2C target that owns 8 or 16 general-purpose pins. The port has one writable output latch and one readable value. There is no direction register and no command byte. A latch bit of 1 releases its pin to a weak pull-up, so an outside source can pull it low and the pin works as an input. A latch bit of 0 drives the pin low. A read returns the live pad levels, not the latch. A pin that this block drives low and an input held low from outside therefore read the same.

The pins appear as a per-bit drive-low enable and a per-bit weak-high indication. The resolved pad level comes back in as an input. An active-low interrupt falls when any synchronised pad level differs from the snapshot taken at the last read. It rises again when the port is read or when the pads return to that snapshot. SCL and SDA are plain inputs from the pads. SDA is driven low through `sda_oe`. The block is a register-level protocol target, so it has no valid/ready stream ports: the I2C ACK bit is its only back-pressure.

Top module: `qbx_expander`

## Requirements
- R1: After reset, `pin_weak_high` is all ones, `pin_drive_low` is zero, `int_n` is 1 and `sda_oe` is 0.
- R2: The block acknowledges only an address byte whose upper seven bits equal {BASE[6:3], `addr_sel`}. BASE is 0x20 when `ALT_BASE`=0 and 0x38 when `ALT_BASE`=1. Bit 0 of the address byte is 1 for a read. After any other address the block stays silent, and the data bytes that follow change nothing.
- R3: For each latch bit, 1 gives `pin_weak_high`=1 and `pin_drive_low`=0, and 0 gives `pin_weak_high`=0 and `pin_drive_low`=1.
- R4: In a write with WIDTH=16, the first data byte goes to bits 7:0 and the second to bits 15:8. The latch changes only after the second byte has been acknowledged. With WIDTH=8, each acknowledged byte updates the whole latch.
- R5: A read returns the synchronised pad levels, not the latch. Bits 7:0 come first, then bits 15:8, and each byte is sent MSB first.
- R6: Further bytes in one write keep alternating between the low and high halves. Each completed pair commits.
- R7: When the master ACKs the last byte of a word, a fresh pad sample is taken and sent in the same order. A master NACK ends the read and leaves SDA released.
- R8: `int_n` is 0 while the synchronised pads differ from the snapshot. The snapshot is all ones at reset and is reloaded at the address ACK of a read and at every fresh sample.
- R9: A START or STOP inside a byte, or between the two bytes of a 16-bit word, leaves the latch unchanged. The next transfer starts again with the low half.
- R10: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| addr_sel | input | 3 | Low three address bits |
| pad_i | input | WIDTH | Resolved pin levels |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_drive_low | output | WIDTH | 1 drives the pin low |
| pin_weak_high | output | WIDTH | 1 releases the pin to the weak pull-up |
| int_n | output | 1 | Active-low pin-change interrupt |

## Verification
The change-detect interrupt and the read sample can land in the same cycle. In that case a pad edge races the snapshot reload that should clear the interrupt. The bench provokes this by moving pads between the bytes of a read, before the master ACK that takes the next sample. It then checks that the next word carries the new level and that `int_n` ends high. The latch commit and a bus STOP can also meet between the two halves of a word. Truncated writes are judged by the pin outputs holding their old value.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ADDR_ACK,
    LK_WR,
    LK_WR_ACK,
    LK_RD,
    LK_RD_ACK
  } link_state_t;

  function automatic logic [6:0] dev_base(input logic alt);
    return alt ? 7'h38 : 7'h20;
  endfunction
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qbx_link.sv
module qbx_link
  import qbx_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter bit ALT_BASE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic [2:0]       addr_sel,
  input  logic [WIDTH-1:0] rd_word,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [7:0]       wr_byte,
  output logic             rd_sample,
  output logic             bus_evt
);
  localparam int LANES = WIDTH / 8;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [6:0] BASE = dev_base(ALT_BASE);

  link_state_t state;
  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_p, stop_p;
  logic [2:0] cnt;
  logic done, rw, mack, ack_q;
  logic [7:0] sh, tx, rd_byte;
  logic [LW-1:0] rd_lane;
  logic [6:0] my_addr;

  assign my_addr  = {BASE[6:3], addr_sel};
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
  assign bus_evt  = start_p | stop_p;
  assign rd_byte  = rd_word[8*int'(rd_lane) +: 8];
  assign wr_byte  = sh;
  assign sda_oe   = ack_q | ((state == LK_RD) & ~tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LK_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      ack_q     <= 1'b0;
      sh        <= '0;
      tx        <= '1;
      rd_lane   <= '0;
      wr_stb    <= 1'b0;
      rd_sample <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      rd_sample <= 1'b0;
      if (start_p) begin
        state <= LK_ADDR;
        cnt   <= '0;
        done  <= 1'b0;
        ack_q <= 1'b0;
      end else if (stop_p) begin
        state <= LK_IDLE;
        done  <= 1'b0;
        ack_q <= 1'b0;
      end else begin
        unique case (state)
          LK_IDLE: ;
          LK_ADDR, LK_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) done <= 1'b1;
            end else if (scl_fall && done) begin
              done <= 1'b0;
              if (state == LK_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  ack_q   <= 1'b1;
                  state   <= LK_ADDR_ACK;
                  rw      <= sh[0];
                  rd_lane <= '0;
                  if (sh[0]) rd_sample <= 1'b1;
                end else begin
                  state <= LK_IDLE;
                end
              end else begin
                ack_q <= 1'b1;
                state <= LK_WR_ACK;
              end
            end
          end
          LK_ADDR_ACK: begin
            if (scl_fall) begin
              ack_q <= 1'b0;
              cnt   <= '0;
              if (rw) begin
                tx    <= rd_byte;
                state <= LK_RD;
              end else begin
                state <= LK_WR;
              end
            end
          end
          LK_WR_ACK: begin
            if (scl_fall) begin
              ack_q  <= 1'b0;
              wr_stb <= 1'b1;
              cnt    <= '0;
              state  <= LK_WR;
            end
          end
          LK_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) done <= 1'b1;
            end else if (scl_fall) begin
              if (done) begin
                done  <= 1'b0;
                tx    <= '1;
                state <= LK_RD_ACK;
              end else begin
                tx <= {tx[6:0], 1'b1};
              end
            end
          end
          LK_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s) begin
                if (rd_lane == LW'(LANES - 1)) begin
                  rd_lane   <= '0;
                  rd_sample <= 1'b1;
                end else begin
                  rd_lane <= rd_lane + 1'b1;
                end
              end
            end else if (scl_fall) begin
              if (mack) begin
                tx    <= rd_byte;
                cnt   <= '0;
                state <= LK_RD;
              end else begin
                state <= LK_IDLE;
              end
            end
          end
          default: state <= LK_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/qbx_port.sv
module qbx_port #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_s,
  input  logic             wr_stb,
  input  logic [7:0]       wr_byte,
  input  logic             bus_evt,
  input  logic             rd_sample,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] snap_q,
  output logic             int_n
);
  localparam int LANES = WIDTH / 8;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0]    lane;
  logic [WIDTH-1:0] stage, stage_nx;

  always_comb begin
    stage_nx = stage;
    stage_nx[8*int'(lane) +: 8] = wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane    <= '0;
      stage   <= '1;
      latch_q <= '1;
    end else if (bus_evt) begin
      lane <= '0;
    end else if (wr_stb) begin
      stage <= stage_nx;
      if (lane == LW'(LANES - 1)) begin
        latch_q <= stage_nx;
        lane    <= '0;
      end else begin
        lane <= lane + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '1;
      int_n  <= 1'b1;
    end else begin
      if (rd_sample) snap_q <= pad_s;
      int_n <= ~|(pad_s ^ snap_q);
    end
  end
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander #(
  parameter int WIDTH = 16,
  parameter bit ALT_BASE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       addr_sel,
  input  logic [WIDTH-1:0] pad_i,
  output logic             sda_oe,
  output logic [WIDTH-1:0] pin_drive_low,
  output logic [WIDTH-1:0] pin_weak_high,
  output logic             int_n
);
  logic [1:0]       bus_s;
  logic [WIDTH-1:0] pad_s, snap, latch;
  logic             wr_stb, rd_sample, bus_evt;
  logic [7:0]       wr_byte;

  qbx_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );

  qbx_sync #(.W(WIDTH), .STAGES(2), .RST_VAL({WIDTH{1'b1}})) u_pad_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_i), .q(pad_s)
  );

  qbx_link #(.WIDTH(WIDTH), .ALT_BASE(ALT_BASE)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .addr_sel(addr_sel), .rd_word(snap), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_sample(rd_sample),
    .bus_evt(bus_evt)
  );

  qbx_port #(.WIDTH(WIDTH)) u_port (
    .clk(clk), .rst_n(rst_n), .pad_s(pad_s), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .bus_evt(bus_evt), .rd_sample(rd_sample),
    .latch_q(latch), .snap_q(snap), .int_n(int_n)
  );

  assign pin_weak_high = latch;
  assign pin_drive_low = ~latch;
endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic             bus_evt,
  input logic             rd_sample,
  input logic [WIDTH-1:0] pad_s,
  input logic [WIDTH-1:0] pin_weak_high,
  input logic             int_n
);
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pin_weak_high));

  // R9
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> $stable(pin_weak_high));

  // R8
  read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample ##1 $stable(pad_s) |=> int_n);

  // R10
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

bind qbx_expander qbx_expander_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .bus_evt(bus_evt), .rd_sample(rd_sample),
  .pad_s(pad_s), .pin_weak_high(pin_weak_high), .int_n(int_n)
);

// File: tb/sim_qbx_expander.sv
`timescale 1ns/1ps
module sim_qbx_expander;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [15:0] ext0 = 16'hFFFF;
  logic [7:0]  ext1 = 8'hFF;
  logic oe0, oe1, int0, int1;
  logic [15:0] drv0, wk0;
  logic [7:0]  drv1, wk1;
  wire sda_bus = sda_m & ~oe0 & ~oe1;
  wire [15:0] pad0 = ext0 & ~drv0;
  wire [7:0]  pad1 = ext1 & ~drv1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string req_q[$];
  logic [7:0] rx_byte;
  event rx_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbx_expander #(.WIDTH(16), .ALT_BASE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(3'b101), .pad_i(pad0), .sda_oe(oe0),
    .pin_drive_low(drv0), .pin_weak_high(wk0), .int_n(int0));

  qbx_expander #(.WIDTH(8), .ALT_BASE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(3'b010), .pad_i(pad1), .sda_oe(oe1),
    .pin_drive_low(drv1), .pin_weak_high(wk1), .int_n(int1));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq();
  endtask

  task automatic i2c_stop();
    sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; hq(); scl_m = 1; hq(); ack = ~sda_bus; hq(); scl_m = 0; hq();
  endtask

  task automatic recv_bits(output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hq(); scl_m = 1; hq(); b[i] = sda_bus; hq(); scl_m = 0; hq();
    end
  endtask

  task automatic send_mack(input logic ack);
    sda_m = ack ? 1'b0 : 1'b1; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq();
    sda_m = 1;
  endtask

  task automatic expect_byte(input string req, input logic [7:0] v);
    req_q.push_back(req);
    exp_q.push_back(v);
  endtask

  task automatic got_byte(input logic [7:0] b);
    rx_byte = b;
    ->rx_ev;
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1,
                         input int n, input logic exp_ack, input string req);
    logic ak;
    i2c_start();
    send_byte({a, 1'b0}, ak);
    chk({req, " address ack"}, 16'(ak), 16'(exp_ack));
    if (n > 0) send_byte(d0, ak);
    if (n > 1) send_byte(d1, ak);
    i2c_stop();
  endtask

  task automatic rd_xfer(input logic [6:0] a, input int n, input string req);
    logic ak;
    logic [7:0] b;
    i2c_start();
    send_byte({a, 1'b1}, ak);
    chk({req, " read address ack"}, 16'(ak), 16'd1);
    for (int i = 0; i < n; i++) begin
      recv_bits(b);
      got_byte(b);
      send_mack(i < n - 1);
    end
    i2c_stop();
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R5 unexpected byte actual=%h expected=none", rx_byte);
      end else begin
        chk(req_q.pop_front(), 16'(rx_byte), 16'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 weak high", wk0, 16'hFFFF);
    chk("R1 drive low", drv0, 16'h0000);
    chk("R1 int_n", 16'(int0), 16'd1);
    chk("R1 sda_oe", 16'({oe0, oe1}), 16'd0);

    // R2 foreign address ignored, data has no effect
    wr_xfer(7'h26, 8'h00, 8'h00, 2, 1'b0, "R2 wrong select");
    wr_xfer(7'h22, 8'h00, 8'h00, 2, 1'b0, "R2 plain base on alt build");
    chk("R2 latch kept u0", wk0, 16'hFFFF);
    chk("R2 latch kept u1", 16'(wk1), 16'h00FF);

    // R4 / R3 two-byte write, low half first
    i2c_start();
    send_byte({7'h25, 1'b0}, ak);
    chk("R2 own address ack", 16'(ak), 16'd1);
    send_byte(8'h5A, ak);
    chk("R4 no update after first byte", wk0, 16'hFFFF);
    send_byte(8'hC3, ak);
    chk("R4 word committed", wk0, 16'hC35A);
    chk("R3 drive low mirrors zeros", drv0, 16'h3CA5);
    i2c_stop();

    // R5 read returns pad levels, not latch
    ext0 = 16'hF0FF;
    expect_byte("R5 low byte pads", 8'h5A);
    expect_byte("R5 high byte pads", 8'hC0);
    rd_xfer(7'h25, 2, "R5");
    repeat (4) @(negedge clk);
    chk("R8 read clears interrupt", 16'(int0), 16'd1);

    // R8 change detect and return
    ext0 = 16'h70FF;
    repeat (6) @(negedge clk);
    chk("R8 change asserts", 16'(int0), 16'd0);
    ext0 = 16'hF0FF;
    repeat (6) @(negedge clk);
    chk("R8 return deasserts", 16'(int0), 16'd1);
    ext0 = 16'h70FF;
    repeat (6) @(negedge clk);
    chk("R8 change asserts again", 16'(int0), 16'd0);
    expect_byte("R5 single byte read", 8'h5A);
    rd_xfer(7'h25, 1, "R8");
    chk("R8 read deasserts", 16'(int0), 16'd1);

    // R7 fresh sample on next word, change lands before master ACK
    ext0 = 16'hFFFF;
    repeat (6) @(negedge clk);
    i2c_start();
    send_byte({7'h25, 1'b1}, ak);
    recv_bits(b); got_byte(b); expect_byte("R7 word1 low", 8'h5A);
    send_mack(1'b1);
    recv_bits(b); got_byte(b); expect_byte("R7 word1 high", 8'hC3);
    ext0 = 16'hFF0F;
    repeat (6) @(negedge clk);
    send_mack(1'b1);
    recv_bits(b); got_byte(b); expect_byte("R7 word2 low fresh", 8'h0A);
    send_mack(1'b1);
    recv_bits(b); got_byte(b); expect_byte("R7 word2 high", 8'hC3);
    send_mack(1'b0);
    hq(); scl_m = 1; hq();
    chk("R7 released after nack", 16'(sda_bus), 16'd1);
    scl_m = 0; hq();
    i2c_stop();
    repeat (4) @(negedge clk);
    chk("R8 sample at ack clears", 16'(int0), 16'd1);

    // R6 extra bytes alternate halves
    i2c_start();
    send_byte({7'h25, 1'b0}, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    send_byte(8'h33, ak);
    chk("R6 first pair", wk0, 16'h2211);
    send_byte(8'h44, ak);
    chk("R6 second pair", wk0, 16'h4433);
    i2c_stop();

    // R9 stop inside a byte
    i2c_start();
    send_byte({7'h25, 1'b0}, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop();
    chk("R9 stop mid byte", wk0, 16'h4433);
    // R9 stop between halves
    wr_xfer(7'h25, 8'h00, 8'h00, 1, 1'b1, "R9");
    chk("R9 stop between halves", wk0, 16'h4433);
    // R9 repeated start between halves restarts at low half
    i2c_start();
    send_byte({7'h25, 1'b0}, ak);
    send_byte(8'h00, ak);
    i2c_start();
    send_byte({7'h25, 1'b0}, ak);
    send_byte(8'h77, ak);
    send_byte(8'h66, ak);
    i2c_stop();
    chk("R9 restart realigns", wk0, 16'h6677);

    // 8-bit alternate-base build
    wr_xfer(7'h3A, 8'h0F, 8'h00, 1, 1'b1, "R2 alt base");
    chk("R4 byte build commit", 16'(wk1), 16'h000F);
    chk("R3 byte build drive", 16'(drv1), 16'h00F0);
    ext1 = 8'hFE;
    expect_byte("R5 byte build pads", 8'h0E);
    expect_byte("R7 byte build repeat", 8'h0E);
    rd_xfer(7'h3A, 2, "R7");
    chk("R2 other device untouched", wk0, 16'h6677);

    repeat (20) @(negedge clk);
    chk("R5 scoreboard drained", 16'(exp_q.size()), 16'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule